// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns register writes into per-processor software interrupts. A processor writes a generation word that names an interrupt ID (0 to 15), a delivery filter and an optional target list. The block marks the interrupt pending at each destination processor and records which processor raised it. One destination can therefore hold the same ID pending from several senders at once.

Each processor can also inspect and change its own bank of pending state through two byte-per-ID register windows. One window sets source bits and the other clears them. Each processor interface sees a pending flag for every ID. When it acknowledges an ID, the interface is given the lowest-numbered sender, and that sender's bit alone is retired. The number of the processor making each write or read arrives as a side input with the access. The block only reports pending state: choosing which interrupt a processor services is left to the interface logic around it.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset no source bit is pending for any processor or ID, `pendAny` is all zero, and `ackHit` is zero.
- R2: A write to offset 0xF00 is a generation request with the filter in bits [25:24], the target list in bits [23:16] and the ID in bits [3:0]. With filter 00, every processor k whose list bit k is 1 gets the ID pending with source bit `wrCpu` set, and the new state is visible one clock after the write.
- R3: Filter 01 delivers to every configured processor except `wrCpu`. Filter 10 delivers only to `wrCpu`.
- R4: A generation write with filter 11 changes nothing. The target list has no effect under filters 01 and 10. List bits at or above `NUM_CPUS` deliver nothing.
- R5: Pending state is kept per source. Requests for the same ID and destination from different senders set separate source bits, each bit s standing for processor s.
- R6: A write to the set window (0xF20 + 4w, w = 0..3) ORs byte k of the data into the writer's own bank for ID 4w+k. Bit s of the byte is source s. Zero bits and bits at or above `NUM_CPUS` have no effect, and other processors' banks are untouched.
- R7: A write to the clear window (0xF10 + 4w) removes the 1-bit sources of byte k from the writer's bank for ID 4w+k. Zero bits have no effect. Reads of either window by `rdCpu` return the same bytes in the same layout.
- R8: `pendAny[c*16+i]` is 1 while processor c has any source pending for ID i. For the ID on `ackId` of processor c, `ackHit` shows whether any source is pending, and `ackSrc` gives the lowest pending source number.
- R9: An acknowledge (`ackEn` high) clears only the reported lowest source bit at the next clock. Any other sources for that ID stay pending.
- R10: When a set, from a generation write or from the set window, hits the same bit as an acknowledge or a clear in the same cycle, the set wins and the bit stays pending.
- R11: The generation register is write-only. Reads of 0xF00, and of any offset outside the two windows, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 12 | Write byte offset |
| wrData | input | 32 | Write data |
| wrCpu | input | 3 | Number of the writing processor |
| rdCpu | input | 3 | Number of the reading processor (selects bank) |
| rdAddr | input | 12 | Read byte offset |
| rdData | output | 32 | Read data for the window at rdAddr |
| ackEn | input | NUM_CPUS | Per-processor acknowledge strobe |
| ackId | input | NUM_CPUS*4 | Per-processor ID being queried or acknowledged |
| ackSrc | output | NUM_CPUS*3 | Per-processor lowest pending source for ackId |
| ackHit | output | NUM_CPUS | Per-processor: some source pending for ackId |
| pendAny | output | NUM_CPUS*16 | Pending flag per processor and ID |

## Verification
A generation request and an acknowledge can land in the same cycle on the same processor, ID and source bit. The set path and the retire path then act on one byte of state at the same edge. The bench provokes this by driving a self-targeted generation write together with `ackEn` for that ID, with the bit already pending. It passes when the bit is still set afterwards. Separately, an acknowledge with two sources pending is judged by reading the window and seeing that only the lower source was retired.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int ID_COUNT = 16;
  localparam int CPU_MAX  = 8;
  localparam int ID_W     = 4;
  localparam int SRC_W    = 3;
  localparam int ADDR_W   = 12;

  localparam logic [ADDR_W-1:0] GEN_ADDR = 12'hF00;
  localparam logic [7:0]        CLR_PAGE = 8'hF1;
  localparam logic [7:0]        SET_PAGE = 8'hF2;

  // strobes from decode to pending store
  typedef struct packed {
    logic               gen;
    logic               setView;
    logic               clrView;
    logic [1:0]         word;
    logic [ID_W-1:0]    id;
    logic [SRC_W-1:0]   writer;
    logic [CPU_MAX-1:0] dest;
    logic [31:0]        data;
  } sgiStrobe_t;

  function automatic logic [SRC_W-1:0] lowIdx(input logic [CPU_MAX-1:0] v);
    logic [SRC_W-1:0] r;
    r = '0;
    for (int k = CPU_MAX - 1; k >= 0; k--) begin
      if (v[k]) r = SRC_W'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [SRC_W-1:0]  wrCpu,
  output sgiStrobe_t        strb
);
  localparam logic [CPU_MAX-1:0] CPU_MASK = CPU_MAX'((16'd1 << NUM_CPUS) - 16'd1);

  logic [1:0]         filt;
  logic [CPU_MAX-1:0] selfBit;
  logic [CPU_MAX-1:0] destRaw;
  logic               isGen;

  assign filt    = wrData[25:24];
  assign selfBit = CPU_MAX'(1) << wrCpu;
  assign isGen   = wrEn && (wrAddr == GEN_ADDR);

  always_comb begin
    unique case (filt)
      2'b00:   destRaw = wrData[23:16];
      2'b01:   destRaw = ~selfBit;
      2'b10:   destRaw = selfBit;
      default: destRaw = '0;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.gen     = isGen && (filt != 2'b11);
    strb.setView = wrEn && (wrAddr[11:4] == SET_PAGE) && (wrAddr[1:0] == 2'b00);
    strb.clrView = wrEn && (wrAddr[11:4] == CLR_PAGE) && (wrAddr[1:0] == 2'b00);
    strb.word    = wrAddr[3:2];
    strb.id      = wrData[3:0];
    strb.writer  = wrCpu;
    strb.dest    = destRaw & CPU_MASK;
    strb.data    = wrData;
  end

  // R3: filter 01 never targets the sender
  a_r3_skip_sender: assert property (@(posedge clk) disable iff (!rstN)
    (strb.gen && wrData[25:24] == 2'b01) |-> !strb.dest[wrCpu]);

  // R3: filter 10 targets at most the sender
  a_r3_self_only: assert property (@(posedge clk) disable iff (!rstN)
    (strb.gen && wrData[25:24] == 2'b10) |-> ($onehot0(strb.dest) && (strb.dest & ~selfBit) == '0));

  // R4: reserved filter raises no request
  a_r4_reserved_filter: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == GEN_ADDR && wrData[25:24] == 2'b11) |-> !strb.gen);
endmodule

// File: rtl/sgi_pending.sv
module sgi_pending
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  sgiStrobe_t                   strb,
  input  logic [NUM_CPUS-1:0]          ackEn,
  input  logic [NUM_CPUS*ID_W-1:0]     ackId,
  input  logic [SRC_W-1:0]             rdCpu,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic [31:0]                  rdData,
  output logic [NUM_CPUS*SRC_W-1:0]    ackSrc,
  output logic [NUM_CPUS-1:0]          ackHit,
  output logic [NUM_CPUS*ID_COUNT-1:0] pendAny
);
  localparam logic [CPU_MAX-1:0] CPU_MASK = CPU_MAX'((16'd1 << NUM_CPUS) - 16'd1);

  logic [NUM_CPUS-1:0][ID_COUNT-1:0][CPU_MAX-1:0] pendQ;
  logic [NUM_CPUS-1:0][ID_COUNT-1:0][CPU_MAX-1:0] pendD;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [CPU_MAX-1:0] selByte;
    logic [ID_W-1:0]    qId;

    for (genvar i = 0; i < ID_COUNT; i++) begin : g_id
      logic [CPU_MAX-1:0] cur;
      logic [CPU_MAX-1:0] lowBit;
      logic [CPU_MAX-1:0] byteIn;
      logic               hitAck;
      logic               hitView;
      logic               hitGen;
      logic [CPU_MAX-1:0] clrMask;
      logic [CPU_MAX-1:0] setMask;

      assign cur     = pendQ[c][i];
      assign lowBit  = cur & (~cur + CPU_MAX'(1));
      assign byteIn  = strb.data[(i % 4) * 8 +: 8];
      assign hitAck  = ackEn[c] && (ackId[c*ID_W +: ID_W] == ID_W'(i));
      assign hitView = (strb.writer == SRC_W'(c)) && (strb.word == 2'(i / 4));
      assign hitGen  = strb.gen && strb.dest[c] && (strb.id == ID_W'(i));
      assign clrMask = (hitAck ? lowBit : '0) | ((hitView && strb.clrView) ? byteIn : '0);
      assign setMask = ((hitView && strb.setView) ? byteIn : '0)
                     | (hitGen ? (CPU_MAX'(1) << strb.writer) : '0);
      // clears first, then sets: a same-cycle set survives
      assign pendD[c][i] = ((cur & ~clrMask) | setMask) & CPU_MASK;
      assign pendAny[c*ID_COUNT + i] = |cur;
    end

    assign qId     = ackId[c*ID_W +: ID_W];
    assign selByte = pendQ[c][qId];
    assign ackHit[c] = |selByte;
    assign ackSrc[c*SRC_W +: SRC_W] = lowIdx(selByte);

    // R8: reported source is pending and lowest
    a_r8_ack_lowest: assert property (@(posedge clk) disable iff (!rstN)
      ackHit[c] |-> (selByte[ackSrc[c*SRC_W +: SRC_W]]
                     && (selByte & ((CPU_MAX'(1) << ackSrc[c*SRC_W +: SRC_W]) - CPU_MAX'(1))) == '0));

    // R9: acknowledged source is retired when no set competes
    a_r9_ack_retires: assert property (@(posedge clk) disable iff (!rstN)
      (ackEn[c] && ackHit[c] && !strb.gen && !strb.setView)
        |=> !pendQ[c][$past(qId)][$past(ackSrc[c*SRC_W +: SRC_W])]);

    // R2: a delivered request records its sender
    a_r2_gen_records: assert property (@(posedge clk) disable iff (!rstN)
      (strb.gen && strb.dest[c] && (int'(strb.writer) < NUM_CPUS))
        |=> pendQ[c][$past(strb.id)][$past(strb.writer)]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendD;
  end

  always_comb begin
    rdData = '0;
    if ((rdAddr[11:4] == SET_PAGE || rdAddr[11:4] == CLR_PAGE) && rdAddr[1:0] == 2'b00
        && int'(rdCpu) < NUM_CPUS) begin
      rdData = pendQ[rdCpu][{rdAddr[3:2], 2'b00} +: 4];
    end
  end

  // R1: without any request the state holds
  a_r1_quiet_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.gen && !strb.setView && !strb.clrView && ackEn == '0) |=> $stable(pendQ));
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [11:0]                  wrAddr,
  input  logic [31:0]                  wrData,
  input  logic [2:0]                   wrCpu,
  input  logic [2:0]                   rdCpu,
  input  logic [11:0]                  rdAddr,
  output logic [31:0]                  rdData,
  input  logic [NUM_CPUS-1:0]          ackEn,
  input  logic [NUM_CPUS*4-1:0]        ackId,
  output logic [NUM_CPUS*3-1:0]        ackSrc,
  output logic [NUM_CPUS-1:0]          ackHit,
  output logic [NUM_CPUS*16-1:0]       pendAny
);
  sgiStrobe_t strb;

  sgi_decode #(.NUM_CPUS(NUM_CPUS)) u_decode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wrCpu(wrCpu), .strb(strb)
  );

  sgi_pending #(.NUM_CPUS(NUM_CPUS)) u_pending (
    .clk(clk), .rstN(rstN), .strb(strb), .ackEn(ackEn), .ackId(ackId),
    .rdCpu(rdCpu), .rdAddr(rdAddr), .rdData(rdData),
    .ackSrc(ackSrc), .ackHit(ackHit), .pendAny(pendAny)
  );
endmodule

// File: tb/sgi_dispatch_bench.sv
`timescale 1ns/1ps
module sgi_dispatch_bench;
  localparam int N = 4;

  logic          clk = 0;
  logic          rstN = 0;
  logic          wrEn = 0;
  logic [11:0]   wrAddr = '0;
  logic [31:0]   wrData = '0;
  logic [2:0]    wrCpu = '0;
  logic [2:0]    rdCpu = '0;
  logic [11:0]   rdAddr = '0;
  logic [31:0]   rdData;
  logic [N-1:0]  ackEn = '0;
  logic [N*4-1:0] ackId = '0;
  logic [N*3-1:0] ackSrc;
  logic [N-1:0]  ackHit;
  logic [N*16-1:0] pendAny;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sgi_dispatch #(.NUM_CPUS(N)) u_sgi_dispatch (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrCpu(wrCpu), .rdCpu(rdCpu), .rdAddr(rdAddr), .rdData(rdData),
    .ackEn(ackEn), .ackId(ackId), .ackSrc(ackSrc), .ackHit(ackHit), .pendAny(pendAny)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] genWord(input logic [1:0] f, input logic [7:0] lst, input logic [3:0] id);
    return {6'b0, f, lst, 12'b0, id};
  endfunction

  task automatic wrReg(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1; wrCpu = 3'(cpu); wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rdByte(input int cpu, input int id, output logic [7:0] b);
    rdCpu = 3'(cpu);
    rdAddr = 12'hF20 + 12'(4 * (id / 4));
    #0.5;
    b = rdData[(id % 4) * 8 +: 8];
  endtask

  task automatic clearAll();
    for (int c = 0; c < N; c++)
      for (int w = 0; w < 4; w++) wrReg(c, 12'hF10 + 12'(4 * w), 32'hFFFF_FFFF);
  endtask

  task automatic tReset();
    logic [7:0] b;
    int bad = 0;
    for (int c = 0; c < N; c++)
      for (int i = 0; i < 16; i++) begin
        rdByte(c, i, b);
        if (b != 0) bad++;
      end
    chk("R1 reset bytes nonzero", 32'(bad), 0);
    chk("R1 pendAny", 32'(pendAny), 0);
    chk("R1 ackHit", 32'(ackHit), 0);
  endtask

  task automatic tListFilter();
    logic [7:0] b;
    wrReg(2, 12'hF00, genWord(2'b00, 8'h0A, 4'd5));
    rdByte(1, 5, b); chk("R2 cpu1 id5", 32'(b), 32'h04);
    rdByte(3, 5, b); chk("R2 cpu3 id5", 32'(b), 32'h04);
    rdByte(0, 5, b); chk("R2 cpu0 id5", 32'(b), 32'h00);
    chk("R8 pendAny after list", 32'(pendAny), 32'((64'd1 << 21) | (64'd1 << 53)));
    clearAll();
  endtask

  task automatic tOtherFilters();
    logic [7:0] b;
    wrReg(3, 12'hF00, genWord(2'b01, 8'h08, 4'd9));
    for (int c = 0; c < N; c++) begin
      rdByte(c, 9, b);
      chk("R3 all-but-sender", 32'(b), (c == 3) ? 32'h0 : 32'h08);
    end
    clearAll();
    wrReg(1, 12'hF00, genWord(2'b10, 8'hFF, 4'd12));
    for (int c = 0; c < N; c++) begin
      rdByte(c, 12, b);
      chk("R3 R4 self-only list ignored", 32'(b), (c == 1) ? 32'h02 : 32'h0);
    end
    clearAll();
  endtask

  task automatic tReserved();
    logic [7:0] b;
    wrReg(0, 12'hF00, genWord(2'b11, 8'hFF, 4'd3));
    chk("R4 reserved filter pendAny", 32'(pendAny), 0);
    wrReg(2, 12'hF00, genWord(2'b00, 8'hF2, 4'd4));
    rdByte(1, 4, b); chk("R4 in-range list bit", 32'(b), 32'h04);
    chk("R4 out-of-range list bits", 32'(pendAny), 32'(64'd1 << 20));
    clearAll();
  endtask

  task automatic tSourcesAndAck();
    logic [7:0] b;
    wrReg(0, 12'hF00, genWord(2'b00, 8'h08, 4'd7));
    wrReg(2, 12'hF00, genWord(2'b00, 8'h08, 4'd7));
    rdByte(3, 7, b); chk("R5 two sources", 32'(b), 32'h05);
    @(negedge clk);
    ackId[15:12] = 4'd7;
    #0.5;
    chk("R8 ackHit", 32'(ackHit[3]), 1);
    chk("R8 ackSrc lowest", 32'(ackSrc[11:9]), 0);
    ackEn[3] = 1;
    @(negedge clk);
    ackEn[3] = 0;
    rdByte(3, 7, b); chk("R9 only lowest retired", 32'(b), 32'h04);
    chk("R8 ackSrc next", 32'(ackSrc[11:9]), 2);
    ackEn[3] = 1;
    @(negedge clk);
    ackEn[3] = 0;
    #0.5;
    chk("R9 ackHit after second ack", 32'(ackHit[3]), 0);
    chk("R8 pendAny cleared", 32'(pendAny), 0);
  endtask

  task automatic tWindows();
    logic [7:0] b;
    wrReg(1, 12'hF24, 32'h0000_F300);
    rdByte(1, 5, b); chk("R6 set byte masked", 32'(b), 32'h03);
    rdByte(1, 4, b); chk("R6 zero byte no effect", 32'(b), 32'h00);
    rdByte(0, 5, b); chk("R6 other bank untouched", 32'(b), 32'h00);
    wrReg(1, 12'hF24, 32'h0000_0400);
    rdByte(1, 5, b); chk("R6 OR semantics", 32'(b), 32'h07);
    wrReg(1, 12'hF14, 32'h0000_0100);
    rdByte(1, 5, b); chk("R7 clear one bit", 32'(b), 32'h06);
    rdCpu = 3'd1; rdAddr = 12'hF14; #0.5;
    chk("R7 clear window read", rdData, 32'h0000_0600);
    rdAddr = 12'hF00; #0.5;
    chk("R11 gen reg reads zero", rdData, 0);
    rdAddr = 12'h000; #0.5;
    chk("R11 other offset zero", rdData, 0);
    clearAll();
  endtask

  task automatic tCollide();
    logic [7:0] b;
    wrReg(0, 12'hF00, genWord(2'b10, 8'h00, 4'd2));
    @(negedge clk);
    wrEn = 1; wrCpu = 3'd0; wrAddr = 12'hF00; wrData = genWord(2'b10, 8'h00, 4'd2);
    ackId[3:0] = 4'd2; ackEn[0] = 1;
    @(negedge clk);
    wrEn = 0; ackEn[0] = 0;
    rdByte(0, 2, b); chk("R10 set beats ack", 32'(b), 32'h01);
    clearAll();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tListFilter();
    tOtherFilters();
    tReserved();
    tSourcesAndAck();
    tWindows();
    tCollide();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule